// File: doc/BRIEF.md
# Pipelined Multi-Hit Index Extractor

This block takes a match vector (for example the hit lines from a content-addressable search) and turns the positions of its set bits into binary indices. It produces up to `HITS` indices per word, in ascending order. A chain of `HITS` registered stages does the work. Each stage finds the lowest set bit still left in the vector and writes its position into its own result slot. It then clears that bit before the vector moves on to the next stage. Because every stage is registered, a new word can enter on every clock. Each word's results leave exactly `HITS` cycles after the word is accepted.

Both the input and the output are valid/ready streams. The whole pipeline advances as one unit. It moves whenever the output slot is empty or the downstream side accepts the word at the output. So `in_ready` equals `out_ready || !out_valid`. While `out_valid` is high and `out_ready` is low, every stage holds its contents. The output word stays stable and the input is refused. A word is accepted on a clock edge where `in_valid && in_ready`. It is consumed on a clock edge where `out_valid && out_ready`. If a vector has more set bits than there are slots, the extra bits are not reported and `out_overflow` is raised with that word.

Top module: `hit_extract`

## Requirements
- R1: Slot k (k = 0 for the first slot) reports the (k+1)-th lowest set bit of the accepted vector, as a binary bit position with bit 0 as the least significant bit. Slot k occupies `out_idx[k*IW +: IW]`, where IW = clog2(WIDTH), so the valid indices are strictly ascending with slot number.
- R2: `out_hit[k]` is 1 exactly when the vector has more than k set bits. When `out_hit[k]` is 0 while `out_valid` is 1, slot k's index is zero.
- R3: `out_overflow` is 1 with a word exactly when that word has more than HITS set bits. It is 0 whenever `out_valid` is 0.
- R4: With `out_ready` held high, a word accepted at clock edge t appears on the output (`out_valid` high) right after edge t+HITS-1. That is a latency of exactly HITS cycles.
- R5: With `out_ready` high, `in_ready` stays high, and one word is accepted on every clock.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the output word is held unchanged on the next cycle. No word is lost, duplicated or reordered under back-pressure.
- R7: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R8: Cycles with `in_valid` low create no output word. The number of output words equals the number of accepted words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector is present |
| in_ready | output | 1 | Pipeline can take a vector this cycle |
| in_vec | input | WIDTH | Match vector to decode |
| out_valid | output | 1 | Result word is present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_idx | output | HITS*IW | Packed bit positions, slot k at bits [k*IW +: IW] |
| out_hit | output | HITS | Per-slot valid bits |
| out_overflow | output | 1 | Vector had more set bits than slots |

## Verification
The assertions make no assumption about the contents of the vector. Vectors with too many set bits are legal and are covered by the overflow property. The hold property does assume the source keeps to the stream rule: a word offered and not taken stays on `in_vec` with `in_valid` high. The stimulus keeps to this rule. A pending word is never withdrawn or changed, and gaps in `in_valid` are inserted only on cycles when no offer is outstanding. The bench sweeps every value of an 8-bit, four-slot configuration twice. The first pass runs at full rate. The second pass runs with gaps and a periodic stall on `out_ready`.

// File: rtl/hit_extract_pkg.sv
package hit_extract_pkg;
  localparam int unsigned XTR_WIDTH_DEFAULT = 32;
  localparam int unsigned XTR_HITS_DEFAULT  = 4;

  function automatic int unsigned idx_width(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/hit_lowest_enc.sv
module hit_lowest_enc #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IW   = hit_extract_pkg::idx_width(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IW-1:0]    pos,
  output logic             found
);
  // Scan from the top down so the lowest set bit is written last and wins.
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) begin
        pos   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hit_stage.sv
module hit_stage #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned HITS  = 4,
  parameter int unsigned SLOT  = 0,
  localparam int unsigned IW   = hit_extract_pkg::idx_width(WIDTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 in_vld,
  input  logic [WIDTH-1:0]     in_vec,
  input  logic [HITS*IW-1:0]   in_idx,
  input  logic [HITS-1:0]      in_hit,
  output logic                 out_vld,
  output logic [WIDTH-1:0]     out_vec,
  output logic [HITS*IW-1:0]   out_idx,
  output logic [HITS-1:0]      out_hit
);
  logic [IW-1:0]      pos;
  logic               found;
  logic [WIDTH-1:0]   low_bit;
  logic [HITS*IW-1:0] nxt_idx;
  logic [HITS-1:0]    nxt_hit;

  hit_lowest_enc #(.WIDTH(WIDTH)) u_enc (
    .vec   (in_vec),
    .pos   (pos),
    .found (found)
  );

  // Isolate the lowest set bit arithmetically; it is cleared before passing on.
  assign low_bit = in_vec & (~in_vec + WIDTH'(1));

  always_comb begin
    nxt_idx = in_idx;
    nxt_hit = in_hit;
    nxt_idx[SLOT*IW +: IW] = pos;
    nxt_hit[SLOT]          = found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_vec <= '0;
      out_idx <= '0;
      out_hit <= '0;
    end else if (en) begin
      out_vld <= in_vld;
      out_vec <= in_vec & ~low_bit;
      out_idx <= nxt_idx;
      out_hit <= nxt_hit;
    end
  end

  // R2: this slot's valid bit records whether anything remained to find.
  assert_slot_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (out_hit[SLOT] == ($past(in_vec) != '0)));

  // R1: the bit reported by this slot is no longer present downstream.
  assert_slot_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit[SLOT] |-> !out_vec[out_idx[SLOT*IW +: IW]]);

  // R1: exactly one bit is removed per stage when a hit is found.
  assert_one_removed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_vec != '0) |=> ($countones(out_vec) + 1 == $countones($past(in_vec))));
endmodule

// File: rtl/hit_extract.sv
module hit_extract #(
  parameter int unsigned WIDTH = hit_extract_pkg::XTR_WIDTH_DEFAULT,
  parameter int unsigned HITS  = hit_extract_pkg::XTR_HITS_DEFAULT,
  localparam int unsigned IW   = hit_extract_pkg::idx_width(WIDTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WIDTH-1:0]   in_vec,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [HITS*IW-1:0] out_idx,
  output logic [HITS-1:0]    out_hit,
  output logic               out_overflow
);
  logic               s_vld [HITS+1];
  logic [WIDTH-1:0]   s_vec [HITS+1];
  logic [HITS*IW-1:0] s_idx [HITS+1];
  logic [HITS-1:0]    s_hit [HITS+1];
  logic               adv;

  // Global advance: the last register is empty or is being drained.
  assign adv      = out_ready || !s_vld[HITS];
  assign in_ready = adv;

  assign s_vld[0] = in_valid;
  assign s_vec[0] = in_vec;
  assign s_idx[0] = '0;
  assign s_hit[0] = '0;

  for (genvar g = 0; g < HITS; g++) begin : g_stage
    hit_stage #(.WIDTH(WIDTH), .HITS(HITS), .SLOT(g)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (adv),
      .in_vld  (s_vld[g]),
      .in_vec  (s_vec[g]),
      .in_idx  (s_idx[g]),
      .in_hit  (s_hit[g]),
      .out_vld (s_vld[g+1]),
      .out_vec (s_vec[g+1]),
      .out_idx (s_idx[g+1]),
      .out_hit (s_hit[g+1])
    );
  end

  assign out_valid    = s_vld[HITS];
  assign out_idx      = s_idx[HITS];
  assign out_hit      = s_hit[HITS];
  assign out_overflow = s_vld[HITS] && (s_vec[HITS] != '0);

  // R6: a stalled result is held and the source is refused.
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_hit)
                                   && $stable(out_overflow)));

  assert_stall_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3: overflow only when every slot is occupied.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_overflow |-> (out_valid && (&out_hit)));

  for (genvar k = 0; k < HITS; k++) begin : g_chk
    // R2: an empty slot carries index zero.
    assert_empty_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_hit[k]) |-> (out_idx[k*IW +: IW] == '0));
    if (k > 0) begin : g_ord
      // R1: slots fill in order, with strictly ascending positions.
      assert_ascending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit[k]) |->
          (out_hit[k-1] && (out_idx[(k-1)*IW +: IW] < out_idx[k*IW +: IW])));
    end
  end
endmodule

// File: tb/hit_extract_test.sv
module hit_extract_test;
  localparam int unsigned W  = 8;
  localparam int unsigned H  = 4;
  localparam int unsigned IW = 3;
  localparam int TOTAL = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_vec = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [H*IW-1:0] out_idx;
  logic [H-1:0] out_hit;
  logic out_overflow;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  hit_extract #(.WIDTH(W), .HITS(H)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec(in_vec), .out_valid(out_valid), .out_ready(out_ready),
    .out_idx(out_idx), .out_hit(out_hit), .out_overflow(out_overflow)
  );

  function automatic logic [W-1:0] word_of(input int n);
    if (n < 256) return W'(n);
    return W'(((n - 256) * 97 + 13) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string msg,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  // Arithmetic expectation: ascending positions, overflow when count exceeds H.
  task automatic check_word(input logic [W-1:0] v);
    logic [H*IW-1:0] e_idx = '0;
    logic [H-1:0]    e_hit = '0;
    int cnt = 0;
    for (int b = 0; b < W; b++) begin
      if (v[b]) begin
        if (cnt < H) begin
          e_idx[cnt*IW +: IW] = IW'(b);
          e_hit[cnt] = 1'b1;
        end
        cnt++;
      end
    end
    check(out_idx == e_idx, "R1", $sformatf("indices for %02h", v), int'(out_idx), int'(e_idx));
    check(out_hit == e_hit, "R2", $sformatf("hits for %02h", v), int'(out_hit), int'(e_hit));
    check(out_overflow == (cnt > H), "R3", $sformatf("overflow for %02h", v),
          int'(out_overflow), int'(cnt > H));
  endtask

  initial begin
    int sent = 0;
    int rx = 0;
    int cyc = 0;
    int stalls = 0;
    bit stuck = 0;
    bit held = 0;
    logic [H*IW-1:0] snap_idx = '0;
    logic [H-1:0] snap_hit = '0;
    logic snap_ovf = 1'b0;

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7", "state in reset",
          int'({out_valid, in_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7", "state after reset",
          int'({out_valid, in_ready}), 1);

    // R4: one word, latency of exactly H cycles.
    in_vec = 8'b0010_0110;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 1; n < 4; n++) begin
      check(out_valid == 1'b0, "R4", $sformatf("early output at cycle %0d", n),
            int'(out_valid), 0);
      @(negedge clk);
    end
    check(out_valid == 1'b1, "R4", "output after four cycles", int'(out_valid), 1);
    if (out_valid) check_word(8'b0010_0110);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "no output from idle cycles", int'(out_valid), 0);

    // Streaming: full rate for the first sweep, gaps and stalls for the second.
    while (rx < TOTAL) begin
      @(negedge clk);
      if (held) begin
        check(out_valid && out_idx == snap_idx && out_hit == snap_hit && out_overflow == snap_ovf,
              "R6", "stalled output held", int'(out_idx), int'(snap_idx));
      end
      out_ready = (sent < 256) ? 1'b1 : ((cyc % 7) < 4);
      in_valid = (sent < TOTAL) && (sent < 256 || stuck || (cyc % 5) != 3);
      in_vec = word_of(sent < TOTAL ? sent : 0);
      #1;
      if (sent < 256 && sent > 0 && !in_ready) stalls++;
      if (out_valid && out_ready) begin
        check_word(word_of(rx));
        rx++;
      end
      held = out_valid && !out_ready;
      snap_idx = out_idx;
      snap_hit = out_hit;
      snap_ovf = out_overflow;
      if (held) check(!in_ready, "R6", "input refused while stalled", int'(in_ready), 0);
      stuck = in_valid && !in_ready;
      if (in_valid && in_ready) sent++;
      cyc++;
      if (cyc > 20000) begin
        check(1'b0, "R8", "watchdog expired", rx, TOTAL);
        break;
      end
    end
    in_valid = 1'b0;
    check(stalls == 0, "R5", "in_ready dropped at full rate", stalls, 0);
    check(rx == TOTAL && sent == TOTAL, "R8", "word count", rx, TOTAL);
    repeat (6) @(negedge clk);
    check(out_valid == 1'b0, "R8", "pipeline drained", int'(out_valid), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule